// File: doc/BRIEF.md
# Shadow ROM Bank Mapper

This block turns a 16-bit CPU address into separate targets for reads and for writes. Each target is a backing-store select and an offset. The address space is treated as 4 KB banks. The upper four address bits name a bank and the lower twelve give the position inside it. Banks are grouped four at a time into 16 KB regions, and every region gets its own read target and write target. A read at an address can therefore hit a ROM while a write to the same address lands in the RAM that the ROM shadows.

A small map register, loaded through an I/O write strobe, chooses the arrangement. Out of reset the register holds an all-ones marker. In that state every region reads the BIOS ROM and no write lands anywhere. The first write to the register replaces the marker with a 3-bit map value, and the new mapping applies from the next clock cycle. Bit 2 of the map value is also exported as the enable for the video memory window. The video window itself is decoded outside this block. Here, that bit turns the third region into a sink that reads as 0xFF.

Top module: `shadow_bank_mapper`

## Requirements
- R1: Read select encoding is 0 = RAM, 1 = BIOS ROM, 2 = BASIC ROM, 3 = dummy (reads as 0xFF). RAM offsets equal the CPU address, BIOS offsets are address bits 13:0, and the dummy offset is 0. `wr_off` always equals the CPU address.
- R2: From reset until the first map write, every address reads BIOS at offset address[13:0], `wr_ram` is 0, and `video_en` is 0.
- R3: While `io_wr` is high, a clock edge loads `io_wdata[2:0]` as the map value and ignores bits 7:3. The new mapping is visible at the ports in the cycle after that edge.
- R4: While `io_wr` is low, the mapping does not change, whatever `io_wdata` carries. Writing the value already held leaves every output unchanged.
- R5: In region 0x0000–0x3FFF, reads come from RAM when map bit 0 is 1. When map bit 0 is 0, they come from BASIC at offset address[13:0].
- R6: In region 0x4000–0x7FFF, reads come from RAM when map bit 1 is 1. Otherwise, map bit 0 = 1 selects BIOS at offset address[13:0], and map bit 0 = 0 selects BASIC at offset address[14:0] (0x4000 + address[13:0]).
- R7: Once a map value is loaded, writes to 0x0000–0x7FFF always go to RAM (`wr_ram` = 1).
- R8: In region 0x8000–0xBFFF, map bit 2 = 1 gives a dummy read and a discarded write. Map bit 2 = 0 gives RAM for both reads and writes.
- R9: Once a map value is loaded, region 0xC000–0xFFFF uses RAM for both reads and writes.
- R10: `video_en` equals map bit 2 once a map value is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Map register write strobe |
| io_wdata | input | 8 | Map register write data; bits 2:0 are used |
| cpu_addr | input | 16 | CPU address |
| rd_sel | output | 2 | Read target select |
| rd_off | output | 16 | Offset into the read target |
| wr_ram | output | 1 | 1 when the write lands in RAM, 0 when it is discarded |
| wr_off | output | 16 | Offset into RAM for the write |
| video_en | output | 1 | Video window enable (map bit 2) |

## Verification
The only internal state is the map value and the reset marker, and all outputs are combinational from that state and the address. A wrong map bit therefore shows at the ports as soon as an address in the affected region is presented, in the cycle right after the faulty load. A marker that clears too early or never clears shows as writes that land when they should not, or as BIOS reads that persist. The bench covers every map value against every bank, at offsets near both edges of each bank and in the middle. This makes any misrouted region visible within one sweep.

// File: rtl/shadow_bank_mapper.sv
module shadow_bank_mapper #(
  parameter int ADDR_W  = 16,
  parameter int REGION_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [1:0]        rd_sel,
  output logic [ADDR_W-1:0] rd_off,
  output logic              wr_ram,
  output logic [ADDR_W-1:0] wr_off,
  output logic              video_en
);
  localparam logic [1:0] SEL_RAM   = 2'd0;
  localparam logic [1:0] SEL_BIOS  = 2'd1;
  localparam logic [1:0] SEL_BASIC = 2'd2;
  localparam logic [1:0] SEL_NONE  = 2'd3;

  logic [2:0] map_q;
  logic       boot_q;
  logic [1:0] region;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q  <= 3'b111;
      boot_q <= 1'b1;
    end else if (io_wr) begin
      map_q  <= io_wdata[2:0];
      boot_q <= 1'b0;
    end
  end

  assign region   = cpu_addr[ADDR_W-1 -: 2];
  assign wr_off   = cpu_addr;
  assign video_en = !boot_q && map_q[2];

  always_comb begin
    rd_sel = SEL_RAM;
    rd_off = cpu_addr;
    wr_ram = 1'b1;
    if (boot_q) begin
      rd_sel = SEL_BIOS;
      rd_off = ADDR_W'(cpu_addr[REGION_W-1:0]);
      wr_ram = 1'b0;
    end else begin
      case (region)
        2'd0: if (!map_q[0]) begin
          rd_sel = SEL_BASIC;
          rd_off = ADDR_W'(cpu_addr[REGION_W-1:0]);
        end
        2'd1: if (!map_q[1]) begin
          if (map_q[0]) begin
            rd_sel = SEL_BIOS;
            rd_off = ADDR_W'(cpu_addr[REGION_W-1:0]);
          end else begin
            rd_sel = SEL_BASIC;
            rd_off = ADDR_W'(cpu_addr[REGION_W:0]);
          end
        end
        2'd2: if (map_q[2]) begin
          rd_sel = SEL_NONE;
          rd_off = '0;
          wr_ram = 1'b0;
        end
        default: ;
      endcase
    end
  end

  p_boot_bios_r2: assert property (@(posedge clk) disable iff (!rst_n)
    boot_q |-> (rd_sel == SEL_BIOS && !wr_ram && !video_en));
  p_low_write_ram_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_q && !cpu_addr[ADDR_W-1]) |-> (wr_ram && wr_off == cpu_addr));
  p_top_ram_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_q && region == 2'd3) |-> (rd_sel == SEL_RAM && wr_ram && rd_off == cpu_addr));
  p_load_low_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr |=> (map_q == $past(io_wdata[2:0]) && !boot_q));
  p_hold_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> ($stable(map_q) && $stable(boot_q)));
  p_video_sink_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (video_en && region == 2'd2) |-> (rd_sel == SEL_NONE && !wr_ram));
  p_dummy_only_mid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_NONE) |-> (region == 2'd2 && rd_off == '0));
endmodule

// File: tb/test_shadow_bank_mapper.sv
module test_shadow_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [15:0] cpu_addr = 16'h0000;
  logic [1:0]  rd_sel;
  logic [15:0] rd_off;
  logic        wr_ram;
  logic [15:0] wr_off;
  logic        video_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shadow_bank_mapper i_shadow_bank_mapper (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_wdata(io_wdata),
    .cpu_addr(cpu_addr), .rd_sel(rd_sel), .rd_off(rd_off),
    .wr_ram(wr_ram), .wr_off(wr_off), .video_en(video_en)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h addr=%04h", tag, act, exp, cpu_addr);
    end
  endtask

  task automatic map_write(input logic [7:0] v);
    @(negedge clk);
    io_wr = 1'b1;
    io_wdata = v;
    @(negedge clk);
    io_wr = 1'b0;
    io_wdata = ~v;
  endtask

  // boot = 1 models the reset marker; m is the loaded map value
  task automatic check_addr(input bit boot, input logic [2:0] m, input logic [15:0] a);
    logic [1:0]  es;
    logic [15:0] eo;
    logic        ew;
    string       rt;
    string       wt;
    @(negedge clk);
    cpu_addr = a;
    #1;
    es = 2'd0; eo = a; ew = 1'b1;
    case (a[15:14])
      2'd0: begin rt = "R5"; wt = "R7"; end
      2'd1: begin rt = "R6"; wt = "R7"; end
      2'd2: begin rt = "R8"; wt = "R8"; end
      default: begin rt = "R9"; wt = "R9"; end
    endcase
    if (boot) begin
      es = 2'd1; eo = {2'b00, a[13:0]}; ew = 1'b0; rt = "R2"; wt = "R2";
    end else if (a[15:14] == 2'd0 && !m[0]) begin
      es = 2'd2; eo = {2'b00, a[13:0]};
    end else if (a[15:14] == 2'd1 && !m[1]) begin
      if (m[0]) begin es = 2'd1; eo = {2'b00, a[13:0]}; end
      else begin es = 2'd2; eo = {2'b01, a[13:0]}; end
    end else if (a[15:14] == 2'd2 && m[2]) begin
      es = 2'd3; eo = 16'h0000; ew = 1'b0;
    end
    check(rt, int'(rd_sel), int'(es));
    check("R1", int'(rd_off), int'(eo));
    check(wt, int'(wr_ram), int'(ew));
    check("R1", int'(wr_off), int'(a));
    check(boot ? "R2" : "R10", int'(video_en), boot ? 0 : int'(m[2]));
  endtask

  task automatic sweep(input bit boot, input logic [2:0] m);
    for (int b = 0; b < 16; b++) begin
      check_addr(boot, m, {b[3:0], 12'h000});
      check_addr(boot, m, {b[3:0], 12'h5A3});
      check_addr(boot, m, {b[3:0], 12'hFFF});
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sweep(1'b1, 3'd0);
        for (int m = 0; m < 8; m++) begin
          map_write({5'b00000, m[2:0]});
          sweep(1'b0, m[2:0]);
        end
        // R3: upper data bits ignored
        map_write(8'hFC);
        check_addr(1'b0, 3'd4, 16'h9123);
        check("R3", int'(video_en), 1);
        map_write(8'hF9);
        sweep(1'b0, 3'd1);
        // R4: strobe low with changing data, then an equal rewrite
        for (int k = 0; k < 8; k++) begin
          @(negedge clk);
          io_wdata = 8'(k * 37);
        end
        check_addr(1'b0, 3'd1, 16'h4ABC);
        check("R4", int'(rd_sel), 1);
        map_write(8'h01);
        sweep(1'b0, 3'd1);
        check("R4", int'(video_en), 0);
        done = 1'b1;
      end
      begin
        repeat (50000) @(posedge clk);
        if (!done) begin
          errors++;
          checks++;
          $display("FAIL watchdog actual=timeout expected=completion");
        end
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule